// File: doc/BRIEF.md
# Low-Quadword Vector Move Unit

This execution unit carries out the vector instruction that moves one 64-bit double-precision element between memory and the least significant quadword of a vector register. The instruction-fetch side passes in fields it has already decoded: encoding class, mandatory-prefix presence, opcode byte, ModRM mode, the second-source register field, the vector-length bits and the W bit. The register file supplies the current destination/source register and bits [127:64] of the register named by the second-source field. The load path supplies the 64-bit memory read data.

The unit decides whether the instruction is a load, a store or an undefined opcode. A load produces a full-width register write-back value. Its upper part depends on the encoding class: the old contents are kept, or the second-source quadword is merged in and everything above bit 127 is cleared. A store produces 64 bits of store data. A fault suppresses both writes. All results appear one clock after the issue cycle.

Top module: `lqmove_unit`

## Requirements
- R1: With `pfx_66` high, opcode 8'h12 is the load form and opcode 8'h13 is the store form. Any other opcode, or `pfx_66` low, raises `ud_fault`.
- R2: A legacy (`enc_cls`=0) load writes `mem_rdata` to bits [63:0] of `rf_wdata` and copies every bit from 64 upward unchanged from `src_dst_data`.
- R3: A VEX (`enc_cls`=1) or EVEX (`enc_cls`=2) load writes `mem_rdata` to bits [63:0] and `src_v_hi` to bits [127:64], and clears bits [VL-1:128].
- R4: A store in any legal encoding raises `mem_we` with `mem_wdata` equal to `src_dst_data[63:0]`, and leaves `rf_we` low.
- R5: A VEX or EVEX store with `vvvv` other than 4'b1111 raises `ud_fault`. `vvvv` has no effect on legacy stores or on loads.
- R6: A VEX encoding with `vl[0]`=1, or an EVEX encoding with `vl` other than 2'b00, raises `ud_fault`. `vl[1]` is ignored for VEX, and `vl` is ignored for legacy.
- R7: `modrm_mod`=2'b11 (register operand) raises `ud_fault`. Modes 0 to 2 are legal.
- R8: An EVEX encoding with `w`=0 raises `ud_fault`. `w` has no effect for VEX or legacy.
- R9: Encoding class 3 is reserved and raises `ud_fault`. While `ud_fault` is high, `rf_we` and `mem_we` are both low.
- R10: Outputs change one clock after a cycle with `issue_vld` high. Without an issue, `rf_we`, `mem_we` and `ud_fault` are low and both data outputs hold their last written value. Reset clears every output.
- R11: Data passes bit-exact with no floating-point interpretation, including NaN and denormal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An instruction is presented this cycle |
| enc_cls | input | 2 | 0 legacy, 1 VEX, 2 EVEX, 3 reserved |
| pfx_66 | input | 1 | Mandatory 66 prefix present or implied |
| opc | input | 8 | Opcode byte |
| modrm_mod | input | 2 | ModRM mode field |
| vvvv | input | 4 | Second-source register field as encoded |
| vl | input | 2 | Vector-length bits (L in bit 0 for VEX) |
| w | input | 1 | W bit |
| src_dst_data | input | VL | Destination register (load) or source register (store) |
| src_v_hi | input | 64 | Bits [127:64] of the register named by vvvv |
| mem_rdata | input | 64 | Memory read data |
| rf_we | output | 1 | Register write-back enable |
| rf_wdata | output | VL | Register write-back value |
| mem_we | output | 1 | Memory store enable |
| mem_wdata | output | 64 | Memory store data |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench builds the unit with the default VL of 512. This gives a 384-bit region above bit 127, so both outcomes for that region are observable on wide random values: cleared by the VEX/EVEX load and kept by the legacy load. Directed cases cover each fault cause and each field that must be ignored. A long random run then mixes legal and illegal field combinations against a behavioural model.

// File: rtl/lqmove_pkg.sv
package lqmove_pkg;
  localparam int QW = 64;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_cls_e;

  localparam logic [7:0] OPC_LOAD  = 8'h12;
  localparam logic [7:0] OPC_STORE = 8'h13;
  localparam logic [1:0] MOD_REG   = 2'b11;
  localparam logic [3:0] VVVV_NONE = 4'b1111;
endpackage

// File: rtl/lqmove_decode.sv
module lqmove_decode
  import lqmove_pkg::*;
(
  input  logic [1:0] enc_cls,
  input  logic       pfx_66,
  input  logic [7:0] opc,
  input  logic [1:0] modrm_mod,
  input  logic [3:0] vvvv,
  input  logic [1:0] vl,
  input  logic       w,
  output logic       is_load,
  output logic       is_store,
  output logic       vec_form,
  output logic       bad_len,
  output logic       bad_vvvv,
  output logic       ud
);
  enc_cls_e ec;
  logic bad_enc, bad_opc, bad_mod, bad_w;

  assign ec       = enc_cls_e'(enc_cls);
  assign is_load  = pfx_66 && (opc == OPC_LOAD);
  assign is_store = pfx_66 && (opc == OPC_STORE);
  assign vec_form = (ec == ENC_VEX) || (ec == ENC_EVEX);

  assign bad_enc  = (ec == ENC_RSVD);
  assign bad_opc  = !(is_load || is_store);
  assign bad_mod  = (modrm_mod == MOD_REG);
  assign bad_len  = ((ec == ENC_VEX) && vl[0]) || ((ec == ENC_EVEX) && (vl != 2'b00));
  assign bad_w    = (ec == ENC_EVEX) && !w;
  assign bad_vvvv = vec_form && is_store && (vvvv != VVVV_NONE);

  assign ud = bad_enc | bad_opc | bad_mod | bad_len | bad_w | bad_vvvv;
endmodule

// File: rtl/lqmove_merge.sv
module lqmove_merge
  import lqmove_pkg::*;
#(
  parameter int VL = 512
)(
  input  logic            vec_form,
  input  logic [VL-65:0]  old_hi,
  input  logic [QW-1:0]   v_hi,
  input  logic [QW-1:0]   mem,
  output logic [VL-1:0]   wdata
);
  localparam int UPPER = VL - 2*QW;

  function automatic logic [QW-1:0] pick_q1(input logic vf,
                                            input logic [QW-1:0] keep,
                                            input logic [QW-1:0] merged);
    return vf ? merged : keep;
  endfunction

  assign wdata[QW-1:0]    = mem;
  assign wdata[2*QW-1:QW] = pick_q1(vec_form, old_hi[QW-1:0], v_hi);

  generate
    if (UPPER > 0) begin : g_upper
      assign wdata[VL-1:2*QW] = vec_form ? '0 : old_hi[VL-65:QW];
    end
  endgenerate
endmodule

// File: rtl/lqmove_unit.sv
module lqmove_unit
  import lqmove_pkg::*;
#(
  parameter int VL = 512
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_vld,
  input  logic [1:0]    enc_cls,
  input  logic          pfx_66,
  input  logic [7:0]    opc,
  input  logic [1:0]    modrm_mod,
  input  logic [3:0]    vvvv,
  input  logic [1:0]    vl,
  input  logic          w,
  input  logic [VL-1:0] src_dst_data,
  input  logic [63:0]   src_v_hi,
  input  logic [63:0]   mem_rdata,
  output logic          rf_we,
  output logic [VL-1:0] rf_wdata,
  output logic          mem_we,
  output logic [63:0]   mem_wdata,
  output logic          ud_fault
);
  logic is_load, is_store, vec_form, bad_len, bad_vvvv, dec_ud;
  logic fire_load, fire_store, fire_fault;
  logic [VL-1:0] merged;

  lqmove_decode u_dec (
    .enc_cls(enc_cls), .pfx_66(pfx_66), .opc(opc), .modrm_mod(modrm_mod),
    .vvvv(vvvv), .vl(vl), .w(w),
    .is_load(is_load), .is_store(is_store), .vec_form(vec_form),
    .bad_len(bad_len), .bad_vvvv(bad_vvvv), .ud(dec_ud)
  );

  lqmove_merge #(.VL(VL)) u_mrg (
    .vec_form(vec_form), .old_hi(src_dst_data[VL-1:QW]),
    .v_hi(src_v_hi), .mem(mem_rdata), .wdata(merged)
  );

  assign fire_fault = issue_vld && dec_ud;
  assign fire_load  = issue_vld && !dec_ud && is_load;
  assign fire_store = issue_vld && !dec_ud && is_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we     <= 1'b0;
      mem_we    <= 1'b0;
      ud_fault  <= 1'b0;
      rf_wdata  <= '0;
      mem_wdata <= '0;
    end else begin
      rf_we    <= fire_load;
      mem_we   <= fire_store;
      ud_fault <= fire_fault;
      if (fire_load)  rf_wdata  <= merged;
      if (fire_store) mem_wdata <= src_dst_data[QW-1:0];
    end
  end

  assert_fault_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!rf_we && !mem_we));

  assert_single_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, ud_fault}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> (!rf_we && !mem_we && !ud_fault));

  assert_low_from_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_load |=> (rf_wdata[QW-1:0] == $past(mem_rdata)));

  assert_legacy_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_load && !vec_form) |=> (rf_wdata[VL-1:QW] == $past(src_dst_data[VL-1:QW])));

  assert_merge_q1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_load && vec_form) |=> (rf_wdata[2*QW-1:QW] == $past(src_v_hi)));

  generate
    if (VL > 2*QW) begin : g_zero_chk
      assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_load && vec_form) |=> (rf_wdata[VL-1:2*QW] == '0));
    end
  endgenerate

  assert_store_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_store |=> (mem_we && mem_wdata == $past(src_dst_data[QW-1:0])));

  assert_vvvv_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && bad_vvvv) |=> ud_fault);

  assert_len_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && bad_len) |=> ud_fault);

  assert_regmode_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && modrm_mod == MOD_REG) |=> ud_fault);
endmodule

// File: tb/lqmove_unit_test.sv
`timescale 1ns/1ps
module lqmove_unit_test;
  localparam int VL = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_vld = 1'b0;
  logic [1:0] enc_cls = 2'd0;
  logic pfx_66 = 1'b0;
  logic [7:0] opc = 8'h00;
  logic [1:0] modrm_mod = 2'd0;
  logic [3:0] vvvv = 4'd0;
  logic [1:0] vl = 2'd0;
  logic w = 1'b0;
  logic [VL-1:0] src_dst_data = '0;
  logic [63:0] src_v_hi = '0;
  logic [63:0] mem_rdata = '0;
  logic rf_we, mem_we, ud_fault;
  logic [VL-1:0] rf_wdata;
  logic [63:0] mem_wdata;

  int checks = 0;
  int failures = 0;

  logic e_rf_we = 1'b0, e_mem_we = 1'b0, e_ud = 1'b0;
  logic [VL-1:0] e_rf_wdata = '0;
  logic [63:0] e_mem_wdata = '0;

  always #2 clk = ~clk;

  lqmove_unit #(.VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .enc_cls(enc_cls),
    .pfx_66(pfx_66), .opc(opc), .modrm_mod(modrm_mod), .vvvv(vvvv), .vl(vl),
    .w(w), .src_dst_data(src_dst_data), .src_v_hi(src_v_hi),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .ud_fault(ud_fault)
  );

  function automatic logic [VL-1:0] rand_wide();
    logic [VL-1:0] r;
    for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Behavioural reference: updates expected outputs from the inputs now applied.
  task automatic model_step();
    bit legal;
    bit is_ld, is_st;
    legal = 1;
    is_ld = (opc == 8'h12);
    is_st = (opc == 8'h13);
    if (!pfx_66 || !(is_ld || is_st)) legal = 0;
    if (modrm_mod == 2'b11) legal = 0;
    case (enc_cls)
      2'd0: ;
      2'd1: begin
        if (vl[0]) legal = 0;
        if (is_st && vvvv != 4'hF) legal = 0;
      end
      2'd2: begin
        if (vl != 2'b00) legal = 0;
        if (!w) legal = 0;
        if (is_st && vvvv != 4'hF) legal = 0;
      end
      default: legal = 0;
    endcase
    e_rf_we  = issue_vld && legal && is_ld;
    e_mem_we = issue_vld && legal && is_st;
    e_ud     = issue_vld && !legal;
    if (e_rf_we) begin
      for (int b = 0; b < VL; b++) begin
        if (b < 64)               e_rf_wdata[b] = mem_rdata[b];
        else if (enc_cls == 2'd0) e_rf_wdata[b] = src_dst_data[b];
        else if (b < 128)         e_rf_wdata[b] = src_v_hi[b-64];
        else                      e_rf_wdata[b] = 1'b0;
      end
    end
    if (e_mem_we) e_mem_wdata = src_dst_data[63:0];
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rf_we !== e_rf_we || mem_we !== e_mem_we || ud_fault !== e_ud ||
        rf_wdata !== e_rf_wdata || mem_wdata !== e_mem_wdata) begin
      failures++;
      $display("FAIL %s: we/mwe/ud act=%b%b%b exp=%b%b%b rf act=%h exp=%h mem act=%h exp=%h",
               tag, rf_we, mem_we, ud_fault, e_rf_we, e_mem_we, e_ud,
               rf_wdata, e_rf_wdata, mem_wdata, e_mem_wdata);
    end
  endtask

  // Called just after a falling edge with inputs set; samples at next falling edge.
  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_op(input logic [1:0] ec, input logic [7:0] op,
                        input logic [1:0] md, input logic [3:0] vv,
                        input logic [1:0] l, input logic wb);
    issue_vld = 1'b1; pfx_66 = 1'b1; enc_cls = ec; opc = op;
    modrm_mod = md; vvvv = vv; vl = l; w = wb;
    src_dst_data = rand_wide(); src_v_hi = {$urandom, $urandom};
    mem_rdata = {$urandom, $urandom};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not complete act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    set_op(2'd0, 8'h12, 2'd0, 4'h0, 2'd0, 1'b0); step("R2 legacy load keeps upper");
    set_op(2'd0, 8'h12, 2'd2, 4'h5, 2'd3, 1'b1); step("R6 legacy ignores vl");
    set_op(2'd1, 8'h12, 2'd1, 4'h3, 2'd0, 1'b0); step("R3 VEX load merge and clear");
    set_op(2'd2, 8'h12, 2'd0, 4'h9, 2'd0, 1'b1); step("R3 EVEX load merge and clear");
    set_op(2'd1, 8'h12, 2'd0, 4'h0, 2'd0, 1'b1); step("R5 vvvv ignored on load");

    set_op(2'd0, 8'h13, 2'd0, 4'h2, 2'd0, 1'b0); step("R4 legacy store");
    set_op(2'd0, 8'h13, 2'd1, 4'h0, 2'd0, 1'b0); step("R5 legacy store ignores vvvv");
    set_op(2'd1, 8'h13, 2'd0, 4'hF, 2'd0, 1'b0); step("R4 VEX store");
    set_op(2'd2, 8'h13, 2'd2, 4'hF, 2'd0, 1'b1); step("R4 EVEX store");
    set_op(2'd1, 8'h13, 2'd0, 4'hE, 2'd0, 1'b0); step("R5 VEX store bad vvvv");
    set_op(2'd2, 8'h13, 2'd0, 4'h7, 2'd0, 1'b1); step("R5 EVEX store bad vvvv");

    set_op(2'd1, 8'h12, 2'd0, 4'hF, 2'd1, 1'b0); step("R6 VEX L=1");
    set_op(2'd1, 8'h12, 2'd0, 4'hF, 2'd2, 1'b0); step("R6 VEX vl[1] ignored");
    set_op(2'd2, 8'h12, 2'd0, 4'hF, 2'd1, 1'b1); step("R6 EVEX vl=1");
    set_op(2'd2, 8'h13, 2'd0, 4'hF, 2'd2, 1'b1); step("R6 EVEX vl=2");

    set_op(2'd0, 8'h12, 2'd3, 4'h0, 2'd0, 1'b0); step("R7 legacy reg mode");
    set_op(2'd2, 8'h13, 2'd3, 4'hF, 2'd0, 1'b1); step("R7 EVEX reg mode");

    set_op(2'd2, 8'h12, 2'd0, 4'hF, 2'd0, 1'b0); step("R8 EVEX W=0");
    set_op(2'd1, 8'h12, 2'd0, 4'hF, 2'd0, 1'b1); step("R8 VEX W=1 ignored");

    set_op(2'd0, 8'h14, 2'd0, 4'h0, 2'd0, 1'b0); step("R1 other opcode");
    set_op(2'd0, 8'h12, 2'd0, 4'h0, 2'd0, 1'b0); pfx_66 = 1'b0;
    step("R1 missing prefix");
    set_op(2'd3, 8'h12, 2'd0, 4'hF, 2'd0, 1'b1); step("R9 reserved encoding");

    set_op(2'd0, 8'h12, 2'd0, 4'h0, 2'd0, 1'b0);
    mem_rdata = 64'h7FF8_0000_0000_0001; step("R11 NaN load bit-exact");
    set_op(2'd0, 8'h13, 2'd0, 4'h0, 2'd0, 1'b0);
    src_dst_data[63:0] = 64'h0000_0000_0000_0001; step("R11 denormal store bit-exact");

    issue_vld = 1'b0; opc = 8'h12; src_dst_data = rand_wide();
    mem_rdata = {$urandom, $urandom}; step("R10 idle holds data");
    step("R10 idle second cycle");

    for (int n = 0; n < 400; n++) begin
      set_op($urandom_range(0, 3), ($urandom_range(0, 7) == 0) ? 8'h11 : 8'h12 + ($urandom & 1),
             ($urandom_range(0, 5) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
             ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF,
             ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd0,
             ($urandom_range(0, 4) != 0));
      pfx_66 = ($urandom_range(0, 15) != 0);
      issue_vld = ($urandom_range(0, 5) != 0);
      step("R9 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule